// File: doc/BRIEF.md
# Serial Slow-Control Slave with Sticky Hit Register

This block is the configuration and status port of a multichannel detector front end. A host reaches it over a four-wire synchronous serial link made of clock, enable, data in and data out. Every transfer is a fixed-length frame with the following fields, in order:

- one ignored lead bit;
- a direction flag;
- a seven-bit register address;
- a 72-bit payload, one bit per channel.

On a read the block sends the selected register back on the data-out wire. On a write it stores the payload only once the whole frame has arrived.

The block keeps a sticky hit register. A channel's bit goes high when that channel's discriminator fires, unless the channel is blocked by the inhibit register. A bit stays high until a dedicated clear input is applied. An OR of all hit bits gives a single trigger flag. A host-written readout mask leaves the block as a parallel vector, and a data-acquisition sequencer uses it to choose which channels to digitise.

All serial pins and discriminator lines are brought into one system clock domain through two-flop synchronisers. Edges of the serial clock are detected in that domain. The system clock must therefore run at least about eight times faster than the serial clock.

Top module: `sc_hit_slave`

## Requirements
- R1: A frame is counted in rising serial-clock edges while enable is high. The fields, in order, are:
  - bit 0 is ignored;
  - bit 1 is the direction flag (1 = read, 0 = write);
  - bits 2 to 8 are the address, most significant bit first;
  - bits 9 to 80 are the payload, channel 71 first.

  A write takes effect only after the 81st rising edge.
- R2: On a read frame, data-out changes on falling serial-clock edges. Channel 71 appears after the falling edge that follows the ninth rising edge, and the remaining channels follow in descending order. The output-enable is high while those bits are presented.
- R3: A hit bit is set when its discriminator line is high for at least two system clocks and the channel is not inhibited. Once set, it stays set. The hit register is read at address 0x01.
- R4: A one-cycle pulse on the clear input zeroes every hit bit. The clear takes priority over a hit in the same cycle.
- R5: The inhibit register, at address 0x03, is readable and writable and resets to all zeros. A channel whose inhibit bit is 1 never sets its hit bit.
- R6: The trigger flag output is high exactly when at least one hit bit is set.
- R7: The readout mask, at address 0x02, is readable and writable. It resets to all ones and is driven continuously on the mask output.
- R8: Address 0x01 is read-only. A write frame to it leaves the hit register and the trigger flag unchanged.
- R9: Any address other than 0x01, 0x02 and 0x03 reads back as all zeros. A write to such an address changes no register.
- R10: If enable drops before the 81st rising edge, the frame is abandoned and no register changes. The next frame is decoded normally.
- R11: While enable is low, and after reset, data-out and output-enable are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_clk | input | 1 | Serial clock from the host |
| sc_en | input | 1 | Frame enable, active high |
| sc_din | input | 1 | Serial data from the host |
| sc_dout | output | 1 | Serial data to the host |
| sc_dout_oe | output | 1 | High while sc_dout carries read data |
| disc_in | input | NCH | Per-channel discriminator outputs |
| hit_clr | input | 1 | Clears the hit register |
| hit_any | output | 1 | OR of all hit bits |
| rd_mask | output | NCH | Readout channel mask |

## Verification
The bench builds the block with its default parameters: 72 channels and a seven-bit address, which gives full 81-bit frames. With these values, the outermost channels 0 and 71 can be driven and read back. The address extremes 0x00 and 0x7F can also be used as unmapped locations. Frames abandoned early in the header and midway through the payload exercise both places where an abort can land.

// File: rtl/sc_hit_pkg.sv
// Shared constants for the serial slow-control slave: address width and
// the decoded register locations. Assumes a 7-bit address field.
package sc_hit_pkg;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] A_HIT  = 7'h01;
    localparam logic [ADDR_W-1:0] A_MASK = 7'h02;
    localparam logic [ADDR_W-1:0] A_INH  = 7'h03;
endpackage

// File: rtl/scs_sync.sv
// Multi-bit, multi-stage synchroniser into the system clock domain.
// Each bit is treated independently; assumes the inputs are levels that
// are held for longer than STAGES clocks.
module scs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // shift the raw inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scs_frame.sv
// Serial frame engine. It counts rising serial-clock edges while enable is
// high and decodes the flag, address and payload fields. For a write it
// pulses wr_stb after the last bit. For a read it shifts rd_word out on
// falling edges. Assumes sck_rise and sck_fall are single-cycle pulses
// that are never high together.
module scs_frame #(
    parameter int NCH    = 72,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              din,
    input  logic [NCH-1:0]    rd_word,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic [NCH-1:0]    wr_data,
    output logic              dout,
    output logic              dout_oe
);
    localparam int HDR   = 2 + ADDR_W;
    localparam int FRAME = HDR + NCH;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] HDR_C   = CW'(HDR);
    localparam logic [CW-1:0] FRAME_C = CW'(FRAME);
    localparam logic [CW-1:0] LAST_C  = CW'(FRAME - 1);

    logic [CW-1:0]  cnt;
    logic           rw_q;
    logic [NCH-1:0] wsh;
    logic [NCH-1:0] rsh;

    // capture the header and payload on rising edges; commit on the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            rw_q   <= 1'b0;
            addr   <= '0;
            wsh    <= '0;
            wr_stb <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            wr_stb <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (sck_rise && cnt != FRAME_C) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(1)) begin
                    rw_q <= din;
                end else if (cnt >= CW'(2) && cnt < HDR_C) begin
                    addr <= {addr[ADDR_W-2:0], din};
                end else if (cnt >= HDR_C) begin
                    wsh <= {wsh[NCH-2:0], din};
                    if (cnt == LAST_C && !rw_q) wr_stb <= 1'b1;
                end
            end
        end
    end

    // drive read data on falling edges, loading the word after the header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
            rsh     <= '0;
        end else if (!en) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (sck_fall) begin
            if (rw_q && cnt >= HDR_C && cnt < FRAME_C) begin
                dout_oe <= 1'b1;
                if (cnt == HDR_C) begin
                    dout <= rd_word[NCH-1];
                    rsh  <= {rd_word[NCH-2:0], 1'b0};
                end else begin
                    dout <= rsh[NCH-1];
                    rsh  <= {rsh[NCH-2:0], 1'b0};
                end
            end else begin
                dout <= 1'b0;
            end
        end
    end

    assign wr_data = wsh;

    // R1: a commit happens only on a completed write frame
    a_r1_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (cnt == FRAME_C && !rw_q));
    // R10: a dropped enable never lets a commit through
    a_r10_no_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wr_stb);
    // R11: the output is quiet after enable is low
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!dout && !dout_oe));
    // R2: the output is enabled only inside read frames
    a_r2_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> rw_q);
endmodule

// File: rtl/scs_hitreg.sv
// Sticky per-channel hit register. A channel bit sets on a synchronised
// discriminator level unless that channel is inhibited, and all bits clear
// on a clear pulse (the clear wins). Assumes hit_clr is synchronous to clk.
module scs_hitreg #(
    parameter int NCH = 72
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [NCH-1:0] disc,
    input  logic [NCH-1:0] inh,
    output logic [NCH-1:0] hit,
    output logic           any
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // latch one channel's hit until a clear
        always_ff @(posedge clk) begin
            if (!rst_n || clr) hit[g] <= 1'b0;
            else if (disc[g] && !inh[g]) hit[g] <= 1'b1;
        end
    end

    assign any = |hit;

    // R3: set bits persist while no clear is applied
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((hit & $past(hit)) == $past(hit)));
    // R4: a clear empties the register
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hit == '0));
    // R5: no newly set bit belongs to an inhibited channel
    a_r5_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((hit & ~$past(hit) & $past(inh)) == '0));
endmodule

// File: rtl/sc_hit_slave.sv
// Top of the serial slow-control slave. It synchronises the serial pins and
// discriminator lines, detects serial-clock edges, and holds the readout
// mask and inhibit registers. It also routes reads from the hit register.
// Assumes clk is at least about 8x faster than sc_clk.
module sc_hit_slave
    import sc_hit_pkg::*;
#(
    parameter int NCH = 72
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sc_clk,
    input  logic           sc_en,
    input  logic           sc_din,
    output logic           sc_dout,
    output logic           sc_dout_oe,
    input  logic [NCH-1:0] disc_in,
    input  logic           hit_clr,
    output logic           hit_any,
    output logic [NCH-1:0] rd_mask
);
    logic [2:0]        pin_s;
    logic              sck_d;
    logic              sck_rise;
    logic              sck_fall;
    logic [NCH-1:0]    disc_s;
    logic [NCH-1:0]    hit_vec;
    logic [NCH-1:0]    inh_q;
    logic [NCH-1:0]    mask_q;
    logic [NCH-1:0]    rd_word;
    logic [NCH-1:0]    wr_data;
    logic [ADDR_W-1:0] addr;
    logic              wr_stb;

    scs_sync #(.W(3), .STAGES(2)) u_pin_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sc_clk, sc_en, sc_din}), .q(pin_s)
    );

    scs_sync #(.W(NCH), .STAGES(2)) u_disc_sync (
        .clk(clk), .rst_n(rst_n), .d(disc_in), .q(disc_s)
    );

    // remember the previous serial-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= pin_s[2];
    end

    assign sck_rise = pin_s[2] & ~sck_d;
    assign sck_fall = ~pin_s[2] & sck_d;

    scs_frame #(.NCH(NCH), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(pin_s[1]),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .din(pin_s[0]),
        .rd_word(rd_word), .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data),
        .dout(sc_dout), .dout_oe(sc_dout_oe)
    );

    scs_hitreg #(.NCH(NCH)) u_hit (
        .clk(clk), .rst_n(rst_n), .clr(hit_clr), .disc(disc_s),
        .inh(inh_q), .hit(hit_vec), .any(hit_any)
    );

    // update the writable registers on a committed write frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            inh_q  <= '0;
        end else if (wr_stb) begin
            if (addr == A_MASK) mask_q <= wr_data;
            if (addr == A_INH)  inh_q  <= wr_data;
        end
    end

    // choose the read word; unmapped addresses give zeros
    always_comb begin
        case (addr)
            A_HIT:   rd_word = hit_vec;
            A_MASK:  rd_word = mask_q;
            A_INH:   rd_word = inh_q;
            default: rd_word = '0;
        endcase
    end

    assign rd_mask = mask_q;

    // R7: the mask changes only on a committed write to its address
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && addr == A_MASK) |=> $stable(mask_q));
    // R9: the inhibit register changes only on a write to its address
    a_r9_inh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && addr == A_INH) |=> $stable(inh_q));
endmodule

// File: tb/tb_sc_hit_slave.sv
module tb_sc_hit_slave;
    localparam int NCH   = 72;
    localparam int HDR   = 9;
    localparam int FRAME = HDR + NCH;
    localparam int HALF  = 8;

    logic clk = 0, rst_n = 0;
    logic sc_clk = 0, sc_en = 0, sc_din = 0, hit_clr = 0;
    logic [NCH-1:0] disc_in = '0;
    logic sc_dout, sc_dout_oe, hit_any;
    logic [NCH-1:0] rd_mask;

    int total = 0, bad = 0;
    bit done = 0;
    logic [NCH-1:0] exp_hit, exp_mask, exp_inh, rv;
    bit oe_ok;

    sc_hit_slave #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .sc_clk(sc_clk), .sc_en(sc_en),
        .sc_din(sc_din), .sc_dout(sc_dout), .sc_dout_oe(sc_dout_oe),
        .disc_in(disc_in), .hit_clr(hit_clr), .hit_any(hit_any),
        .rd_mask(rd_mask)
    );

    always #4 clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] rand72();
        logic [95:0] t;
        t = {$urandom, $urandom, $urandom};
        return t[NCH-1:0];
    endfunction

    // one serial frame; stop_at < FRAME drops enable after that many bits
    task automatic frame(input bit rd, input logic [6:0] a,
                         input logic [NCH-1:0] wd, input int stop_at,
                         output logic [NCH-1:0] rdv, output bit oe_good);
        rdv = '0;
        oe_good = 1;
        sc_en = 1;
        wait_clk(HALF);
        for (int i = 0; i < FRAME; i++) begin
            if (i == stop_at) break;
            if (i == 1)                 sc_din = rd;
            else if (i >= 2 && i < HDR) sc_din = a[HDR-1-i];
            else if (i >= HDR)          sc_din = wd[FRAME-1-i];
            else                        sc_din = 1'b1;
            wait_clk(HALF);
            if (rd && i >= HDR) begin
                rdv[FRAME-1-i] = sc_dout;
                if (!sc_dout_oe) oe_good = 0;
            end
            sc_clk = 1;
            wait_clk(HALF);
            sc_clk = 0;
        end
        wait_clk(HALF);
        sc_en = 0;
        sc_din = 0;
        wait_clk(6);
    endtask

    task automatic wr(input logic [6:0] a, input logic [NCH-1:0] d);
        logic [NCH-1:0] dummy;
        bit o;
        frame(0, a, d, FRAME, dummy, o);
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [NCH-1:0] exp,
                          input string req);
        logic [NCH-1:0] v;
        bit o;
        frame(1, a, '0, FRAME, v, o);
        chk(v == exp, req, v, exp);
        chk(o, "R2 output enable during read data", {71'b0, o}, 1);
    endtask

    task automatic hits(input logic [NCH-1:0] pat);
        disc_in = pat;
        wait_clk(2);
        disc_in = '0;
        wait_clk(5);
        exp_hit |= pat & ~exp_inh;
    endtask

    task automatic clear_hits();
        hit_clr = 1;
        wait_clk(1);
        hit_clr = 0;
        wait_clk(1);
        exp_hit = '0;
    endtask

    initial begin
        wait_clk(190000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        exp_hit = '0; exp_mask = '1; exp_inh = '0;
        wait_clk(4);
        rst_n = 1;
        wait_clk(2);
        // R11 reset state
        chk(!sc_dout && !sc_dout_oe, "R11 quiet after reset",
            {70'b0, sc_dout, sc_dout_oe}, '0);
        chk(rd_mask == '1, "R7 mask resets to ones", rd_mask, '1);
        chk(!hit_any, "R6 flag low after reset", {71'b0, hit_any}, '0);
        rd_chk(7'h02, '1, "R7 mask readback after reset");
        rd_chk(7'h03, '0, "R5 inhibit resets to zero");
        rd_chk(7'h01, '0, "R3 hit empty after reset");

        // boundary channels 0 and 71 (R1 ordering, R3, R6)
        hits({1'b1, 70'b0, 1'b1});
        chk(hit_any, "R6 flag after edge hits", {71'b0, hit_any}, 1);
        rd_chk(7'h01, exp_hit, "R1 R3 edge channel order");
        clear_hits();
        chk(!hit_any, "R4 flag cleared", {71'b0, hit_any}, '0);
        rd_chk(7'h01, '0, "R4 hit cleared");

        // random rounds
        for (int k = 0; k < 6; k++) begin
            exp_inh = rand72();
            wr(7'h03, exp_inh);
            rd_chk(7'h03, exp_inh, "R5 inhibit readback");
            exp_mask = rand72();
            wr(7'h02, exp_mask);
            chk(rd_mask == exp_mask, "R7 mask output", rd_mask, exp_mask);
            rd_chk(7'h02, exp_mask, "R7 mask readback");
            hits(rand72());
            hits(rand72());
            rd_chk(7'h01, exp_hit, "R3 R5 hit pattern");
            chk(hit_any == (exp_hit != '0), "R6 trigger flag",
                {71'b0, hit_any}, {71'b0, exp_hit != '0});
            // R8 write to read-only hit address
            wr(7'h01, ~exp_hit);
            rd_chk(7'h01, exp_hit, "R8 hit unaffected by write");
            if (k % 2 == 1) begin
                clear_hits();
                rd_chk(7'h01, '0, "R4 clear after random hits");
            end
        end

        // R5 fully inhibited: no hits at all
        clear_hits();
        exp_inh = '1;
        wr(7'h03, exp_inh);
        hits('1);
        chk(!hit_any, "R5 all inhibited keeps flag low", {71'b0, hit_any}, '0);
        rd_chk(7'h01, '0, "R5 all inhibited no hits");
        exp_inh = '0;
        wr(7'h03, exp_inh);

        // R9 unmapped addresses
        rd_chk(7'h00, '0, "R9 unmapped 0x00 reads zero");
        rd_chk(7'h7F, '0, "R9 unmapped 0x7F reads zero");
        wr(7'h7F, 72'h55);
        wr(7'h00, 72'hAA);
        rd_chk(7'h02, exp_mask, "R9 mask unchanged by unmapped write");
        rd_chk(7'h03, exp_inh, "R9 inhibit unchanged by unmapped write");

        // R10 aborted frames
        begin
            logic [NCH-1:0] v;
            bit o;
            frame(0, 7'h02, ~exp_mask, 40, v, o);
            chk(rd_mask == exp_mask, "R10 abort mid payload", rd_mask, exp_mask);
            frame(0, 7'h02, ~exp_mask, 80, v, o);
            chk(rd_mask == exp_mask, "R10 abort one bit short", rd_mask, exp_mask);
            frame(0, 7'h03, '1, 5, v, o);
            rd_chk(7'h03, exp_inh, "R10 abort in header");
            chk(!sc_dout && !sc_dout_oe, "R11 quiet when enable low",
                {70'b0, sc_dout, sc_dout_oe}, '0);
        end
        exp_mask = 72'h80_0000_0000_0000_0001;
        wr(7'h02, exp_mask);
        chk(rd_mask == exp_mask, "R10 next frame decodes", rd_mask, exp_mask);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule